// File: doc/BRIEF.md
# Sparse I/O Register Window Decoder

This block sits behind a host I/O port and decides which legacy, widely spaced I/O addresses belong to it. Each access that matches a fixed sparse pattern is mapped to a 32-bit internal register. The mapping takes the register index from high address bits and passes it through an index table. The low two address bits pick the starting byte lane. The access size may be one, two or four bytes. A narrow write replaces only the addressed bytes, and a narrow read returns the addressed bytes right-justified.

The window also owns a configuration register that no other path can reach. Its two low bits choose the linear aperture: off, 4 MB with the register block placed high, or 8 MB with the register block placed low. A status register with a fixed type bit is read-only. Every request gets a response one clock later that reports whether it was claimed, together with warning and error pulses.

Top module: `sparse_io_window`

## Requirements
- R1: An access is claimed only when (address AND 0xFFFF03FC) equals 0x2EC. Address bit 15 is therefore a don't-care. Each request (ioReq high for one cycle) yields rspValid exactly one cycle later, carrying that request's response.
- R2: A matching access with ioEnable low is not claimed. It raises rspWarn in its response cycle and changes no register.
- R3: Address bits 14:10 form the index. Indexes 0 to 29 each select their own register. Index 31 aliases index 0. Index 30 is unbacked: it reads zero and writes to it are dropped.
- R4: ioSize gives the access size in bytes (1, 2 or 4), and address bits 1:0 give the starting lane. A read returns the selected bytes shifted down to bit 0, with zeros in every byte lane above the access size.
- R5: A write stores the data bytes, taken from bit 0 upward, into the addressed lanes. All other bytes of the register keep their values.
- R6: A claimed access whose size is not 1, 2 or 4, or whose lane plus size exceeds 4, is claimed with rspSizeErr high. It writes nothing and returns zero read data.
- R7: Index 28 is a status register that always reads 0x00000200. Writes to it are discarded.
- R8: Index 26 is the configuration register, and its bits 1:0 set the aperture outputs. 0 gives apLinearOn=0. 1 gives apLinearOn=1, ap8M=0, apRegsHigh=1. 2 gives apLinearOn=1, ap8M=1, apRegsHigh=0. 3 gives apLinearOn=0, and a write that leaves the value 3 pulses rspApErr in its response cycle.
- R9: After reset all registers, including the configuration register, read zero, and all response and aperture outputs are low.
- R10: The response to a write always carries rspRdata equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioReq | input | 1 | One-cycle I/O request strobe |
| ioWrite | input | 1 | 1 = write, 0 = read |
| ioAddr | input | 32 | I/O byte address |
| ioSize | input | 3 | Access size in bytes |
| ioWdata | input | 32 | Write data, right-justified |
| ioEnable | input | 1 | I/O space enable from the command register |
| rspValid | output | 1 | Response for the previous cycle's request |
| rspClaim | output | 1 | Access was claimed |
| rspWarn | output | 1 | Matching access refused because I/O space is off |
| rspSizeErr | output | 1 | Claimed access with illegal size or lane overflow |
| rspApErr | output | 1 | Configuration write left an invalid aperture code |
| rspRdata | output | 32 | Read data, right-justified |
| apLinearOn | output | 1 | Linear aperture enabled |
| ap8M | output | 1 | Aperture is 8 MB |
| apRegsHigh | output | 1 | Register block at the upper aperture offset |

## Verification
Two things happen in the same clock edge when a narrow write reaches the configuration register: the byte merge, and the decode of the invalid aperture code. The bench first puts a nonzero byte in lane 1, then writes 0x03 to lane 0 alone. It expects rspApErr in that response, apLinearOn low, and a later word read of 0x00007A03, which shows the untouched lane survived the merge. Spill rejections are also swept across every lane and size.

// File: rtl/sparse_io_pkg.sv
package sparse_io_pkg;
  localparam int DW       = 32;
  localparam int NBYTES   = DW / 8;
  localparam int IDX_W    = 5;
  localparam int IDX_LSB  = 10;
  localparam int NUM_REGS = 30;
  localparam int REG_W    = $clog2(NUM_REGS);
  localparam logic [DW-1:0] MATCH_MASK  = 32'hFFFF03FC;
  localparam logic [DW-1:0] SPARSE_BASE = 32'h000002EC;
  localparam logic [IDX_W-1:0] CFG_IDX   = 5'd26;
  localparam logic [IDX_W-1:0] STAT_IDX  = 5'd28;
  localparam logic [IDX_W-1:0] VOID_IDX  = 5'd30;
  localparam logic [IDX_W-1:0] ALIAS_IDX = 5'd31;

  typedef enum logic [1:0] {TGT_FILE, TGT_CFG, TGT_STAT, TGT_VOID} target_e;

  typedef struct packed {
    logic             claim;
    logic             warn;
    logic             wrEn;
    logic             rdEn;
    logic             sizeErr;
    target_e          target;
    logic [REG_W-1:0] regNum;
    logic [1:0]       lane;
    logic [2:0]       nBytes;
  } strobe_t;

  function automatic target_e idxTarget(input logic [IDX_W-1:0] idx);
    if (idx == CFG_IDX)       return TGT_CFG;
    else if (idx == STAT_IDX) return TGT_STAT;
    else if (idx == VOID_IDX) return TGT_VOID;
    else                      return TGT_FILE;
  endfunction

  function automatic logic [REG_W-1:0] idxToReg(input logic [IDX_W-1:0] idx);
    if (idx == ALIAS_IDX) return '0;
    else                  return REG_W'(idx);
  endfunction
endpackage

// File: rtl/sparse_io_ctrl.sv
module sparse_io_ctrl
  import sparse_io_pkg::*;
(
  input  logic          ioReq,
  input  logic          ioWrite,
  input  logic [DW-1:0] ioAddr,
  input  logic [2:0]    ioSize,
  input  logic          ioEnable,
  output strobe_t       stb
);
  logic             hit;
  logic             sizeLegal;
  logic             fits;
  logic [IDX_W-1:0] idx;

  always_comb begin
    hit       = (ioAddr & MATCH_MASK) == SPARSE_BASE;
    idx       = ioAddr[IDX_LSB +: IDX_W];
    sizeLegal = (ioSize == 3'd1) || (ioSize == 3'd2) || (ioSize == 3'd4);
    fits      = ({2'b00, ioAddr[1:0]} + {1'b0, ioSize}) <= 4'd4;

    stb         = '0;
    stb.claim   = ioReq && hit && ioEnable;
    stb.warn    = ioReq && hit && !ioEnable;
    stb.sizeErr = stb.claim && !(sizeLegal && fits);
    stb.wrEn    = stb.claim && ioWrite && !stb.sizeErr;
    stb.rdEn    = stb.claim && !ioWrite && !stb.sizeErr;
    stb.target  = idxTarget(idx);
    stb.regNum  = idxToReg(idx);
    stb.lane    = ioAddr[1:0];
    stb.nBytes  = ioSize;
  end
endmodule

// File: rtl/sparse_io_datapath.sv
module sparse_io_datapath
  import sparse_io_pkg::*;
#(
  parameter logic [31:0] STATUS_VALUE = 32'h00000200
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ioReq,
  input  logic [DW-1:0] ioWdata,
  input  strobe_t       stb,
  output logic          rspValid,
  output logic          rspClaim,
  output logic          rspWarn,
  output logic          rspSizeErr,
  output logic          rspApErr,
  output logic [DW-1:0] rspRdata,
  output logic          apLinearOn,
  output logic          ap8M,
  output logic          apRegsHigh
);
  logic [DW-1:0]     regFile [NUM_REGS];
  logic [DW-1:0]     cfgReg;
  logic [DW-1:0]     curVal, shiftedW, shiftedR, mergedVal, readVal;
  logic [NBYTES-1:0] sizeMask, laneMask;

  always_comb begin
    unique case (stb.target)
      TGT_FILE: curVal = regFile[stb.regNum];
      TGT_CFG:  curVal = cfgReg;
      TGT_STAT: curVal = STATUS_VALUE;
      default:  curVal = '0;
    endcase
    unique case (stb.nBytes)
      3'd1:    sizeMask = 4'b0001;
      3'd2:    sizeMask = 4'b0011;
      default: sizeMask = 4'b1111;
    endcase
    laneMask = sizeMask << stb.lane;
    shiftedW = ioWdata << {stb.lane, 3'b000};
    shiftedR = curVal >> {stb.lane, 3'b000};
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign mergedVal[8*b +: 8] = laneMask[b] ? shiftedW[8*b +: 8] : curVal[8*b +: 8];
    assign readVal[8*b +: 8]   = sizeMask[b] ? shiftedR[8*b +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
      cfgReg     <= '0;
      rspValid   <= 1'b0;
      rspClaim   <= 1'b0;
      rspWarn    <= 1'b0;
      rspSizeErr <= 1'b0;
      rspApErr   <= 1'b0;
      rspRdata   <= '0;
    end else begin
      rspValid   <= ioReq;
      rspClaim   <= stb.claim;
      rspWarn    <= stb.warn;
      rspSizeErr <= stb.sizeErr;
      rspApErr   <= stb.wrEn && (stb.target == TGT_CFG) && (mergedVal[1:0] == 2'b11);
      rspRdata   <= stb.rdEn ? readVal : '0;
      if (stb.wrEn) begin
        if (stb.target == TGT_FILE)     regFile[stb.regNum] <= mergedVal;
        else if (stb.target == TGT_CFG) cfgReg <= mergedVal;
      end
    end
  end

  always_comb begin
    unique case (cfgReg[1:0])
      2'b01:   {apLinearOn, ap8M, apRegsHigh} = 3'b101;
      2'b10:   {apLinearOn, ap8M, apRegsHigh} = 3'b110;
      default: {apLinearOn, ap8M, apRegsHigh} = 3'b000;
    endcase
  end
endmodule

// File: rtl/sparse_io_window.sv
module sparse_io_window
  import sparse_io_pkg::*;
#(
  parameter logic [31:0] STATUS_VALUE = 32'h00000200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ioReq,
  input  logic        ioWrite,
  input  logic [31:0] ioAddr,
  input  logic [2:0]  ioSize,
  input  logic [31:0] ioWdata,
  input  logic        ioEnable,
  output logic        rspValid,
  output logic        rspClaim,
  output logic        rspWarn,
  output logic        rspSizeErr,
  output logic        rspApErr,
  output logic [31:0] rspRdata,
  output logic        apLinearOn,
  output logic        ap8M,
  output logic        apRegsHigh
);
  strobe_t stb;

  sparse_io_ctrl u_ctrl (
    .ioReq(ioReq), .ioWrite(ioWrite), .ioAddr(ioAddr),
    .ioSize(ioSize), .ioEnable(ioEnable), .stb(stb)
  );

  sparse_io_datapath #(.STATUS_VALUE(STATUS_VALUE)) u_dp (
    .clk(clk), .rstN(rstN), .ioReq(ioReq), .ioWdata(ioWdata), .stb(stb),
    .rspValid(rspValid), .rspClaim(rspClaim), .rspWarn(rspWarn),
    .rspSizeErr(rspSizeErr), .rspApErr(rspApErr), .rspRdata(rspRdata),
    .apLinearOn(apLinearOn), .ap8M(ap8M), .apRegsHigh(apRegsHigh)
  );
endmodule

// File: rtl/sparse_io_window_chk.sv
module sparse_io_window_chk (
  input logic        clk,
  input logic        rstN,
  input logic        ioReq,
  input logic        ioWrite,
  input logic [31:0] ioAddr,
  input logic [2:0]  ioSize,
  input logic        ioEnable,
  input logic        rspValid,
  input logic        rspClaim,
  input logic        rspWarn,
  input logic        rspSizeErr,
  input logic        rspApErr,
  input logic [31:0] rspRdata,
  input logic        apLinearOn
);
  p_resp_follows_req_r1: assert property (@(posedge clk) disable iff (!rstN)
    ioReq |=> rspValid);

  p_claim_needs_enable_r2: assert property (@(posedge clk) disable iff (!rstN)
    rspClaim |-> $past(ioEnable));

  p_warn_not_claimed_r2: assert property (@(posedge clk) disable iff (!rstN)
    rspWarn |-> !rspClaim);

  p_narrow_read_upper_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && $past(ioSize) == 3'd1) |-> rspRdata[31:8] == 24'h0);

  p_size_err_no_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    rspSizeErr |-> (rspClaim && rspRdata == 32'h0));

  p_status_fixed_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rspClaim && !rspSizeErr && !$past(ioWrite) && $past(ioAddr[14:10]) == 5'd28
     && $past(ioAddr[1:0]) == 2'd0 && $past(ioSize) == 3'd4) |-> rspRdata == 32'h200);

  p_bad_aperture_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspApErr |-> !apLinearOn);

  p_write_rdata_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && $past(ioWrite)) |-> rspRdata == 32'h0);
endmodule

bind sparse_io_window sparse_io_window_chk chk_i (
  .clk(clk), .rstN(rstN), .ioReq(ioReq), .ioWrite(ioWrite), .ioAddr(ioAddr),
  .ioSize(ioSize), .ioEnable(ioEnable), .rspValid(rspValid), .rspClaim(rspClaim),
  .rspWarn(rspWarn), .rspSizeErr(rspSizeErr), .rspApErr(rspApErr),
  .rspRdata(rspRdata), .apLinearOn(apLinearOn)
);

// File: tb/sparse_io_window_tb_top.sv
module sparse_io_window_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ioReq = 1'b0, ioWrite = 1'b0, ioEnable = 1'b1;
  logic [31:0] ioAddr = '0, ioWdata = '0;
  logic [2:0]  ioSize = 3'd4;
  logic        rspValid, rspClaim, rspWarn, rspSizeErr, rspApErr;
  logic [31:0] rspRdata;
  logic        apLinearOn, ap8M, apRegsHigh;

  int nChecks = 0;
  int nFails  = 0;

  typedef struct {
    logic [35:0] flagsData;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  logic [31:0] mdl [32];
  logic [31:0] mdlCfg;

  always #(CLK_PERIOD/2) clk = ~clk;

  sparse_io_window dut_i (
    .clk(clk), .rstN(rstN), .ioReq(ioReq), .ioWrite(ioWrite), .ioAddr(ioAddr),
    .ioSize(ioSize), .ioWdata(ioWdata), .ioEnable(ioEnable),
    .rspValid(rspValid), .rspClaim(rspClaim), .rspWarn(rspWarn),
    .rspSizeErr(rspSizeErr), .rspApErr(rspApErr), .rspRdata(rspRdata),
    .apLinearOn(apLinearOn), .ap8M(ap8M), .apRegsHigh(apRegsHigh)
  );

  task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Model read of an index according to R3, R7, R8
  function automatic logic [31:0] mdlRead(input logic [4:0] idx);
    if (idx == 5'd26)      return mdlCfg;
    else if (idx == 5'd28) return 32'h200;
    else if (idx == 5'd30) return 32'h0;
    else if (idx == 5'd31) return mdl[0];
    else                   return mdl[idx];
  endfunction

  // Driver: drives one request and pushes its expected response
  task automatic access(input bit wr, input logic [4:0] idx, input logic [1:0] lane,
                        input logic [2:0] sz, input logic [31:0] wd, input bit en,
                        input logic [31:0] extra, input string tag);
    logic [31:0] addr, cur, merged, rd;
    bit hit, legal, claim, apErr;
    addr  = 32'h2EC | ({27'h0, idx} << 10) | {30'h0, lane} | extra;
    hit   = (addr & 32'hFFFF03FC) == 32'h2EC;
    claim = hit && en;
    legal = (sz == 3'd1 || sz == 3'd2 || sz == 3'd4) && (int'(lane) + int'(sz) <= 4);
    cur   = mdlRead(idx);
    rd    = '0;
    apErr = 1'b0;
    if (claim && legal) begin
      if (wr) begin
        merged = cur;
        for (int b = 0; b < int'(sz); b++) merged[8*(int'(lane)+b) +: 8] = wd[8*b +: 8];
        if (idx == 5'd26) begin
          mdlCfg = merged;
          apErr  = merged[1:0] == 2'b11;
        end else if (idx == 5'd31) mdl[0] = merged;
        else if (idx != 5'd28 && idx != 5'd30) mdl[idx] = merged;
      end else begin
        for (int b = 0; b < int'(sz); b++) rd[8*b +: 8] = cur[8*(int'(lane)+b) +: 8];
      end
    end
    @(negedge clk);
    ioReq = 1'b1; ioWrite = wr; ioAddr = addr; ioSize = sz; ioWdata = wd; ioEnable = en;
    expQ.push_back('{ {claim, hit && !en, claim && !legal, apErr, rd}, tag });
    @(negedge clk);
    ioReq = 1'b0;
  endtask

  // Monitor: pops and compares each response
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) check(1'b0, "R1 unexpected response", 36'h0, 36'h0);
      else begin
        exp_t e;
        logic [35:0] act;
        e   = expQ.pop_front();
        act = {rspClaim, rspWarn, rspSizeErr, rspApErr, rspRdata};
        check(act === e.flagsData, e.tag, act, e.flagsData);
      end
    end
  end

  task automatic checkAperture(input string tag);
    logic [2:0] exp;
    case (mdlCfg[1:0])
      2'b01:   exp = 3'b101;
      2'b10:   exp = 3'b110;
      default: exp = 3'b000;
    endcase
    check({apLinearOn, ap8M, apRegsHigh} === exp, tag,
          {33'h0, apLinearOn, ap8M, apRegsHigh}, {33'h0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    check(1'b0, "watchdog expired", 36'h0, 36'h0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    mdlCfg = '0;
    repeat (3) @(negedge clk);
    check({rspValid, rspClaim, rspWarn, rspSizeErr, rspApErr, apLinearOn, ap8M, apRegsHigh} == 8'h0
          && rspRdata == 32'h0, "R9 outputs in reset", {4'h0, rspRdata}, 36'h0);
    rstN = 1'b1;

    access(0, 5'd5, 2'd0, 3'd4, 0, 1, 0, "R9 register reads zero after reset");
    access(0, 5'd26, 2'd0, 3'd4, 0, 1, 0, "R9 config reads zero after reset");
    access(1, 5'd0, 2'd0, 3'd4, 32'hA1B2C3D4, 1, 0, "R10 word write response");
    for (int l = 0; l < 4; l++)
      for (int s = 1; s <= 4; s++)
        access(0, 5'd0, 2'(l), 3'(s), 0, 1, 0, "R4 R6 lane/size read sweep");

    access(1, 5'd3, 2'd0, 3'd4, 32'h11223344, 1, 0, "R5 word write");
    access(1, 5'd3, 2'd2, 3'd1, 32'hFFFFFFEE, 1, 0, "R5 byte write lane 2");
    access(1, 5'd3, 2'd1, 3'd2, 32'h0000BEEF, 1, 0, "R5 half write lane 1");
    access(0, 5'd3, 2'd0, 3'd4, 0, 1, 0, "R5 merged word readback");

    access(0, 5'd31, 2'd0, 3'd4, 0, 1, 0, "R3 alias reads index 0");
    access(1, 5'd31, 2'd0, 3'd4, 32'h0BADF00D, 1, 0, "R3 write via alias");
    access(0, 5'd0, 2'd0, 3'd4, 0, 1, 0, "R3 alias write visible at index 0");
    access(1, 5'd30, 2'd0, 3'd4, 32'hFFFFFFFF, 1, 0, "R3 unbacked write");
    access(0, 5'd30, 2'd0, 3'd4, 0, 1, 0, "R3 unbacked reads zero");

    access(0, 5'd28, 2'd0, 3'd4, 0, 1, 0, "R7 status word");
    access(1, 5'd28, 2'd0, 3'd4, 32'hFFFFFFFF, 1, 0, "R7 status write");
    access(0, 5'd28, 2'd0, 3'd4, 0, 1, 0, "R7 status unchanged");
    access(0, 5'd28, 2'd1, 3'd1, 0, 1, 0, "R7 status byte lane 1");

    access(0, 5'd0, 2'd0, 3'd4, 0, 1, 32'h00010000, "R1 upper address bit mismatch");
    access(0, 5'd0, 2'd0, 3'd4, 0, 1, 32'h00000010, "R1 low field mismatch");
    access(0, 5'd0, 2'd0, 3'd4, 0, 1, 32'h00008000, "R1 bit 15 ignored");

    access(1, 5'd2, 2'd0, 3'd4, 32'h12345678, 0, 0, "R2 disabled write warns");
    access(0, 5'd2, 2'd0, 3'd4, 0, 0, 0, "R2 disabled read warns");
    access(0, 5'd2, 2'd0, 3'd4, 0, 1, 0, "R2 register untouched");

    access(1, 5'd4, 2'd0, 3'd4, 32'h00000055, 1, 0, "R6 setup write");
    access(1, 5'd4, 2'd3, 3'd2, 32'hFFFFFFFF, 1, 0, "R6 spill write rejected");
    access(1, 5'd4, 2'd0, 3'd3, 32'hFFFFFFFF, 1, 0, "R6 size 3 rejected");
    access(0, 5'd4, 2'd0, 3'd4, 0, 1, 0, "R6 register intact");

    access(1, 5'd26, 2'd0, 3'd4, 32'h1, 1, 0, "R8 config write 1");
    checkAperture("R8 aperture 4MB regs high");
    access(1, 5'd26, 2'd0, 3'd4, 32'h2, 1, 0, "R8 config write 2");
    checkAperture("R8 aperture 8MB regs low");
    access(1, 5'd26, 2'd0, 3'd4, 32'h0, 1, 0, "R8 config write 0");
    checkAperture("R8 aperture off");
    access(1, 5'd26, 2'd1, 3'd1, 32'h7A, 1, 0, "R8 config byte lane 1");
    access(1, 5'd26, 2'd0, 3'd1, 32'h03, 1, 0, "R8 invalid code with byte merge");
    checkAperture("R8 invalid code keeps aperture off");
    access(0, 5'd26, 2'd0, 3'd4, 0, 1, 0, "R8 R5 config merged readback");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R1 every request answered", 36'(expQ.size()), 36'h0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule